// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the processor-side engine that turns a level-sensitive interrupt request into entry into a service routine. It owns the code segment and offset, the data, extra and stack segments, the stack pointer and the flags word. When the interrupt-enable flag is set and the current instruction finishes, it acknowledges the requester with a one-cycle active-low pulse and latches an 8-bit vector number from the data bus. It then saves the flags, code segment and offset on a word-wide stack and loads the new offset and segment from a vector table in the lowest kilobyte of memory.

A return strobe runs the reverse path: offset, segment and flags come back off the stack, which also restores the previous enable state. Instruction execution is not modelled. It appears only as a completion strobe, a return strobe and two strobes that set or clear the enable flag. All memory traffic goes through one synchronous word port whose read data is valid in the cycle after the request.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, ds_o, es_o, ss_o, ip_o and sp_o are 0x0000, cs_o is 0xFFFF, flags_o is 0x0000 (enable flag, bit 9, clear), inta_n_o is high and busy_o is low.
- R2: While flags_o bit 9 is 0, irq_i causes no acknowledge. ien_set_i sets bit 9, ien_clr_i clears it, and clear wins when both are high.
- R3: A request is accepted only in a cycle where instr_done_i is high. While instr_done_i is low, irq_i produces no acknowledge.
- R4: inta_n_o goes low for exactly one cycle, in the cycle after the request is accepted.
- R5: The vector number is taken from data_bus_i in the acknowledge cycle.
- R6: In the three cycles after the acknowledge, the block writes flags, then CS, then IP. Each write first lowers SP by 2 and stores at byte address SS*16+SP, truncated to 20 bits. After the flags write, bit 9 (enable) and bit 8 (trap) are 0.
- R7: The block then reads the word at byte address vector*4 into IP and the word at vector*4+2 into CS. All table reads fall below address 1024.
- R8: busy_o is high from the acknowledge cycle until the cycle in which CS is loaded, eight cycles in all. No request is accepted in that window.
- R9: A return strobe reads IP, then CS, then flags from SS*16+SP, adding 2 to SP after each read. This restores all three registers and SP to their values before entry.
- R10: ien_set_i and ien_clr_i have no effect while an entry or return is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Level-sensitive interrupt request |
| instr_done_i | input | 1 | Current instruction has completed |
| ret_i | input | 1 | Return-from-service strobe |
| ien_set_i | input | 1 | Set the interrupt-enable flag |
| ien_clr_i | input | 1 | Clear the interrupt-enable flag |
| data_bus_i | input | 8 | Vector number driven by the requester |
| inta_n_o | output | 1 | Active-low acknowledge pulse |
| busy_o | output | 1 | Entry sequence in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 20 | Byte address of the word access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction offset |
| ds_o | output | 16 | Data segment |
| es_o | output | 16 | Extra segment |
| ss_o | output | 16 | Stack segment |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 16 | Flags word |

## Verification
Several properties are checked on every cycle. An acknowledge needs the enable flag, a request and a completed instruction one cycle earlier. It lasts one cycle and never starts while busy. Each stack write lowers SP by 2, each pop raises it by 2, both flags are clear two cycles after the acknowledge, and table reads stay in the low kilobyte. Only the bench scenarios can show the values in memory and registers. These are the order and content of the three saved words, the IP and CS loaded from random table entries for random vectors, SP wrapping through zero in nested entries, trap-flag clearing after a restored flags word, and full restoration on return.

// File: rtl/ise_pkg.sv
package ise_pkg;
    localparam int WORD_W = 16;
    localparam int VEC_W  = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACK,
        S_PSH_F,
        S_PSH_CS,
        S_PSH_IP,
        S_RD_IP,
        S_LD_IP,
        S_RD_CS,
        S_LD_CS,
        S_POP_IP,
        S_LDP_IP,
        S_POP_CS,
        S_LDP_CS,
        S_POP_F,
        S_LDP_F
    } ise_state_e;

    typedef struct packed {
        ise_state_e        state;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ds;
        logic [WORD_W-1:0] es;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] flags;
        logic [VEC_W-1:0]  vec;
    } ise_regs_t;
endpackage

// File: rtl/ise_phys_addr.sv
module ise_phys_addr #(
    parameter int SEG_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [SEG_W-1:0]  off_i,
    output logic [ADDR_W-1:0] phys_o
);
    localparam int SUM_W = SEG_W + 5;

    logic [SUM_W-1:0] sum;

    // segment shifted by one nibble plus offset, carry beyond ADDR_W dropped
    assign sum    = {1'b0, seg_i, 4'b0000} + {5'b00000, off_i};
    assign phys_o = sum[ADDR_W-1:0];
endmodule

// File: rtl/ise_tbl_addr.sv
module ise_tbl_addr #(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 20
) (
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              hi_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - VEC_W - 2;

    // four bytes per entry: low word is the offset, high word the segment
    assign addr_o = {{PAD_W{1'b0}}, vec_i, hi_i, 1'b0};
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
    import ise_pkg::*;
#(
    parameter int                ADDR_W = 20,
    parameter int                IF_BIT = 9,
    parameter int                TF_BIT = 8,
    parameter logic [WORD_W-1:0] CS_RST = 16'hFFFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              irq_i,
    input  logic              instr_done_i,
    input  logic              ret_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic [VEC_W-1:0]  data_bus_i,
    output logic              inta_n_o,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] cs_o,
    output logic [WORD_W-1:0] ip_o,
    output logic [WORD_W-1:0] ds_o,
    output logic [WORD_W-1:0] es_o,
    output logic [WORD_W-1:0] ss_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] flags_o
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    ise_regs_t q, d;

    logic              is_push;
    logic              use_tbl;
    logic              tbl_hi;
    logic [WORD_W-1:0] stk_off;
    logic [ADDR_W-1:0] stk_addr;
    logic [ADDR_W-1:0] tbl_addr;

    assign is_push = (q.state == S_PSH_F) || (q.state == S_PSH_CS) ||
                     (q.state == S_PSH_IP);
    assign stk_off = is_push ? (q.sp - STEP) : q.sp;

    ise_phys_addr #(.SEG_W(WORD_W), .ADDR_W(ADDR_W)) u_stk_addr (
        .seg_i  (q.ss),
        .off_i  (stk_off),
        .phys_o (stk_addr)
    );

    ise_tbl_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_tbl_addr (
        .vec_i  (q.vec),
        .hi_i   (tbl_hi),
        .addr_o (tbl_addr)
    );

    always_comb begin
        d           = q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        use_tbl     = 1'b0;
        tbl_hi      = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (irq_i && q.flags[IF_BIT] && instr_done_i) begin
                    d.state = S_ACK;
                end else if (ret_i) begin
                    d.state = S_POP_IP;
                end else begin
                    if (ien_set_i) d.flags[IF_BIT] = 1'b1;
                    if (ien_clr_i) d.flags[IF_BIT] = 1'b0;
                end
            end
            S_ACK: begin
                d.vec   = data_bus_i;
                d.state = S_PSH_F;
            end
            S_PSH_F: begin
                mem_req_o      = 1'b1;
                mem_we_o       = 1'b1;
                mem_wdata_o    = q.flags;
                d.sp           = q.sp - STEP;
                d.flags[IF_BIT] = 1'b0;
                d.flags[TF_BIT] = 1'b0;
                d.state        = S_PSH_CS;
            end
            S_PSH_CS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = q.cs;
                d.sp        = q.sp - STEP;
                d.state     = S_PSH_IP;
            end
            S_PSH_IP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = q.ip;
                d.sp        = q.sp - STEP;
                d.state     = S_RD_IP;
            end
            S_RD_IP: begin
                mem_req_o = 1'b1;
                use_tbl   = 1'b1;
                d.state   = S_LD_IP;
            end
            S_LD_IP: begin
                d.ip    = mem_rdata_i;
                d.state = S_RD_CS;
            end
            S_RD_CS: begin
                mem_req_o = 1'b1;
                use_tbl   = 1'b1;
                tbl_hi    = 1'b1;
                d.state   = S_LD_CS;
            end
            S_LD_CS: begin
                d.cs    = mem_rdata_i;
                d.state = S_IDLE;
            end
            S_POP_IP: begin
                mem_req_o = 1'b1;
                d.state   = S_LDP_IP;
            end
            S_LDP_IP: begin
                d.ip    = mem_rdata_i;
                d.sp    = q.sp + STEP;
                d.state = S_POP_CS;
            end
            S_POP_CS: begin
                mem_req_o = 1'b1;
                d.state   = S_LDP_CS;
            end
            S_LDP_CS: begin
                d.cs    = mem_rdata_i;
                d.sp    = q.sp + STEP;
                d.state = S_POP_F;
            end
            S_POP_F: begin
                mem_req_o = 1'b1;
                d.state   = S_LDP_F;
            end
            S_LDP_F: begin
                d.flags = mem_rdata_i;
                d.sp    = q.sp + STEP;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= S_IDLE;
            q.cs    <= CS_RST;
            q.ip    <= '0;
            q.ds    <= '0;
            q.es    <= '0;
            q.ss    <= '0;
            q.sp    <= '0;
            q.flags <= '0;
            q.vec   <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o = use_tbl ? tbl_addr : stk_addr;
    assign inta_n_o   = (q.state != S_ACK);
    assign busy_o     = (q.state == S_ACK)   || (q.state == S_PSH_F) ||
                        (q.state == S_PSH_CS) || (q.state == S_PSH_IP) ||
                        (q.state == S_RD_IP)  || (q.state == S_LD_IP) ||
                        (q.state == S_RD_CS)  || (q.state == S_LD_CS);
    assign cs_o    = q.cs;
    assign ip_o    = q.ip;
    assign ds_o    = q.ds;
    assign es_o    = q.es;
    assign ss_o    = q.ss;
    assign sp_o    = q.sp;
    assign flags_o = q.flags;
endmodule

// File: rtl/ise_chk.sv
module ise_chk #(
    parameter int ADDR_W = 20,
    parameter int IF_BIT = 9,
    parameter int TF_BIT = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_i,
    input logic              instr_done_i,
    input logic              inta_n_o,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [15:0]       sp_o,
    input logic [15:0]       flags_o
);
    // R2: acknowledge only follows a cycle with the enable flag and a request
    p_ack_needs_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_n_o |-> ($past(flags_o[IF_BIT]) && $past(irq_i)));

    // R3: acknowledge only follows a completed instruction
    p_ack_on_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_n_o |-> $past(instr_done_i));

    // R4: acknowledge pulse lasts one cycle
    p_ack_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_n_o |=> inta_n_o);

    // R6: enable and trap flags are clear after the flags word is saved
    p_flags_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_n_o |=> ##1 (!flags_o[IF_BIT] && !flags_o[TF_BIT]));

    // R6: every stack write lowers SP by two
    p_push_sp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> (sp_o == $past(sp_o) - 16'd2));

    // R7: table reads stay in the lowest kilobyte
    p_table_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && busy_o) |-> (mem_addr_o[ADDR_W-1:10] == '0));

    // R8: busy starts with the acknowledge, and no acknowledge starts while busy
    p_busy_from_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !inta_n_o);
    p_no_ack_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_n_o |-> !$past(busy_o));

    // R9: each pop raises SP by two once its data is loaded
    p_pop_sp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_we_o && !busy_o) |=> ##1 (sp_o == $past(sp_o, 2) + 16'd2));
endmodule

bind int_entry_seq ise_chk #(
    .ADDR_W (ADDR_W),
    .IF_BIT (IF_BIT),
    .TF_BIT (TF_BIT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_i        (irq_i),
    .instr_done_i (instr_done_i),
    .inta_n_o     (inta_n_o),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .sp_o         (sp_o),
    .flags_o      (flags_o)
);

// File: tb/tb_int_entry_seq.sv
module tb_int_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0, done = 1'b0, ret = 1'b0, iset = 1'b0, iclr = 1'b0;
    logic [7:0]  dbus = 8'h00;
    logic        inta_n, busy, mreq, mwe;
    logic [19:0] maddr;
    logic [15:0] mwdata;
    logic [15:0] mrdata = 16'h0000;
    logic [15:0] cs, ip, ds, es, ss, sp, flags;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mem [int];

    always #5 clk = ~clk;

    int_entry_seq dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .instr_done_i(done),
        .ret_i(ret), .ien_set_i(iset), .ien_clr_i(iclr), .data_bus_i(dbus),
        .inta_n_o(inta_n), .busy_o(busy), .mem_req_o(mreq), .mem_we_o(mwe),
        .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
        .cs_o(cs), .ip_o(ip), .ds_o(ds), .es_o(es), .ss_o(ss), .sp_o(sp),
        .flags_o(flags)
    );

    function automatic logic [15:0] rd(int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    function automatic int phys(logic [15:0] seg, logic [15:0] off);
        return int'(({4'b0, seg, 4'b0} + {8'b0, off}) & 24'h0FFFFF);
    endfunction

    function automatic int tbl(logic [7:0] v, bit hi);
        return int'(v) * 4 + (hi ? 2 : 0);
    endfunction

    always @(posedge clk) begin
        if (mreq && mwe) mem[int'(maddr)] = mwdata;
        else if (mreq)   mrdata <= rd(int'(maddr));
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // entry with a random table entry; dly cycles of request without completion
    task automatic do_entry(logic [7:0] v, int dly, bit poke_set);
        logic [15:0] f0, c0, i0, s0, ni, nc;
        f0 = flags; c0 = cs; i0 = ip; s0 = sp;
        ni = 16'($urandom); nc = 16'($urandom);
        mem[tbl(v, 1'b0)] = ni;
        mem[tbl(v, 1'b1)] = nc;
        irq = 1'b1; done = 1'b0;
        for (int k = 0; k < dly; k++) begin
            tick();
            check("R3 no ack without completion", {31'b0, inta_n}, 32'd1);
        end
        done = 1'b1;
        tick();
        check("R4 ack low", {31'b0, inta_n}, 32'd0);
        check("R8 busy at ack", {31'b0, busy}, 32'd1);
        dbus = v; irq = 1'b0; done = 1'b0;
        tick();
        check("R4 ack one cycle", {31'b0, inta_n}, 32'd1);
        dbus = ~v;
        iset = poke_set;
        tick();
        iset = 1'b0;
        for (int k = 3; k <= 8; k++) begin
            check("R8 busy window", {31'b0, busy}, 32'd1);
            tick();
        end
        check("R8 busy ends", {31'b0, busy}, 32'd0);
        check("R6 flags saved", {16'b0, rd(phys(ss, s0 - 16'd2))}, {16'b0, f0});
        check("R6 CS saved", {16'b0, rd(phys(ss, s0 - 16'd4))}, {16'b0, c0});
        check("R6 IP saved", {16'b0, rd(phys(ss, s0 - 16'd6))}, {16'b0, i0});
        check("R6 SP lowered", {16'b0, sp}, {16'b0, s0 - 16'd6});
        check("R6 R10 flags after entry", {16'b0, flags}, {16'b0, f0 & 16'hFCFF});
        check("R5 R7 IP from table", {16'b0, ip}, {16'b0, ni});
        check("R5 R7 CS from table", {16'b0, cs}, {16'b0, nc});
    endtask

    task automatic do_return(logic [15:0] ei, logic [15:0] ec,
                             logic [15:0] ef, logic [15:0] es_p);
        ret = 1'b1;
        tick();
        ret = 1'b0;
        repeat (7) tick();
        check("R9 IP restored", {16'b0, ip}, {16'b0, ei});
        check("R9 CS restored", {16'b0, cs}, {16'b0, ec});
        check("R9 flags restored", {16'b0, flags}, {16'b0, ef});
        check("R9 SP restored", {16'b0, sp}, {16'b0, es_p});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 DS", {16'b0, ds}, 32'h0);
        check("R1 ES", {16'b0, es}, 32'h0);
        check("R1 SS", {16'b0, ss}, 32'h0);
        check("R1 IP", {16'b0, ip}, 32'h0);
        check("R1 SP", {16'b0, sp}, 32'h0);
        check("R1 CS", {16'b0, cs}, 32'hFFFF);
        check("R1 flags", {16'b0, flags}, 32'h0);
        check("R1 ack idle", {31'b0, inta_n}, 32'd1);
        check("R1 busy idle", {31'b0, busy}, 32'd0);

        // R2 request ignored while disabled
        irq = 1'b1; done = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R2 no ack while disabled", {31'b0, inta_n}, 32'd1);
            check("R2 not busy while disabled", {31'b0, busy}, 32'd0);
        end
        irq = 1'b0; done = 1'b0;

        // R9 directed pop of a prepared frame with the trap flag set
        mem[0] = 16'h1234; mem[2] = 16'h5678; mem[4] = 16'h0301;
        do_return(16'h1234, 16'h5678, 16'h0301, 16'h0006);

        // R6 trap and enable both cleared on entry; R10 set ignored when busy
        do_entry(8'hFF, 0, 1'b1);
        do_return(16'h1234, 16'h5678, 16'h0301, 16'h0006);

        // R2 set/clear strobes, clear wins
        iclr = 1'b1; tick(); iclr = 1'b0; tick();
        check("R2 clear", {31'b0, flags[9]}, 32'd0);
        iset = 1'b1; tick(); iset = 1'b0; tick();
        check("R2 set", {31'b0, flags[9]}, 32'd1);
        iset = 1'b1; iclr = 1'b1; tick(); iset = 1'b0; iclr = 1'b0; tick();
        check("R2 clear wins", {31'b0, flags[9]}, 32'd0);
        iset = 1'b1; tick(); iset = 1'b0; tick();

        // R3 directed: request waits for completion; lowest usable vector
        do_entry(8'h02, 3, 1'b0);
        do_return(16'h1234, 16'h5678, 16'h0301, 16'h0006);

        // random entries, some nested (SP wraps through zero)
        for (int it = 0; it < 30; it++) begin
            logic [15:0] i1, c1, f1, s1, i2, c2, f2, s2;
            logic [7:0]  v;
            iset = 1'b1; tick(); iset = 1'b0; tick();
            i1 = ip; c1 = cs; f1 = flags; s1 = sp;
            v = 8'(2 + ($urandom % 254));
            do_entry(v, int'($urandom % 4), 1'($urandom));
            if ($urandom % 2 == 1) begin
                iset = 1'b1; tick(); iset = 1'b0; tick();
                i2 = ip; c2 = cs; f2 = flags; s2 = sp;
                v = 8'(2 + ($urandom % 254));
                do_entry(v, int'($urandom % 3), 1'b0);
                do_return(i2, c2, f2, s2);
            end
            do_return(i1, c1, f1, s1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule